// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects 63 interrupt request lines from peripheral modules and presents the processor core with a single 3-bit encoded interrupt level. Levels run from 1 (lowest) to 7 (highest), and 0 means nothing is requesting. Sources 1 to 56 are programmable: software gives each one a level and a priority within that level. Sources 57 to 63 have fixed levels. Every source can be masked on its own, and one global bit silences all of them.

When the core takes an interrupt it must learn which source won. It can do this with a hardware acknowledge, which presents a level and receives a vector one cycle later. It can also do it by reading an acknowledge register on the register bus. Each source has its own vector, equal to 64 plus the source number. A wake-up output is driven without any clock. It signals a pending eligible request, so the device can leave a low-power stop mode even while its clock is gated.

Top module: `pic_top`

## Requirements
- R1: After synchronous reset every individual mask bit is set, the global mask bit is clear, every programmable source has level 0 and priority 0, and irq_level and wake are 0.
- R2: Register address n (1 to 63) holds source n as a byte: bit 7 is the mask (1 = masked), bit 6 reads 0, bits 5:3 are the level and bits 2:0 are the priority. A write to a programmable source takes effect at the clock edge and reads back unchanged.
- R3: Fixed source 56+k (k = 1..7) always has level k and priority 0. Writes to its level and priority bits are ignored, and only its mask bit is writable.
- R4: irq_level is registered. One cycle after the inputs it shows the highest level among eligible pending sources, or 0 if there is none.
- R5: A source is eligible only if its request is high, its mask bit is clear, the global mask is clear and its level is non-zero. A programmable source at level 0 is disabled.
- R6: Bit 0 of address 0 is the global mask. While it is set, irq_level goes to 0, wake is 0 and every acknowledge returns the spurious vector.
- R7: Among eligible sources at the winning level, a fixed source wins over a programmable one. Among programmable sources the higher priority value wins, and a remaining tie goes to the lower source number.
- R8: A winning source n returns vector 64+n. When there is no winner the spurious vector 0xFF is returned.
- R9: A read of address 64 returns, without delay, the vector of the current overall winner. The read has no side effect.
- R10: A hardware acknowledge (ack_req high with a level on ack_lvl) makes ack_valid high in the next cycle. ack_vec then holds the vector of the best eligible source at exactly that level, or 0xFF.
- R11: wake is combinational and is high exactly when at least one eligible source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| irq_req | input | 63 | Request lines, bit i is source i+1 |
| irq_level | output | 3 | Encoded interrupt level to the core |
| wake | output | 1 | Unclocked wake-up indication |
| ack_req | input | 1 | Hardware acknowledge request |
| ack_lvl | input | 3 | Level being acknowledged |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_vec | output | 8 | Acknowledged vector |

## Verification
Some properties are checked by the assertions on every cycle. The global mask must hold the level and wake at zero. A non-zero level must be preceded by wake. Every acknowledge response must be one cycle after its request and carry either a legal vector or the spurious code. A non-spurious acknowledge at some level must never exceed the level currently driven to the core. Other behaviour depends on which source wins: the fixed-over-programmable rule, the priority ordering, the tie on source number, the exact vector, and whether writes to fixed sources are ignored. The bench scenarios show this behaviour by comparing against a model of the ranking rules, under both random configurations and directed ties.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NUM_SRC  = 63;
    localparam int NUM_PROG = 56;
    localparam int LVL_W    = 3;
    localparam int PRI_W    = 3;
    localparam int VEC_W    = 8;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int IDX_W    = $clog2(NUM_SRC + 1);

    localparam logic [VEC_W-1:0]  VEC_BASE     = VEC_W'(64);
    localparam logic [VEC_W-1:0]  VEC_SPURIOUS = '1;
    localparam logic [ADDR_W-1:0] ADDR_GLOBAL  = '0;
    localparam logic [ADDR_W-1:0] ADDR_ACK     = ADDR_W'(64);

    typedef struct packed {
        logic             masked;
        logic [LVL_W-1:0] level;
        logic [PRI_W-1:0] prio;
    } src_cfg_t;

    // Ranking key: compares as one unsigned number, larger wins.
    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             fixed;
        logic [PRI_W-1:0] prio;
        logic [IDX_W-1:0] rank;   // inverted index, so lower source number wins ties
    } arb_key_t;

    function automatic arb_key_t make_key(src_cfg_t c, logic fixed, logic [IDX_W-1:0] idx);
        arb_key_t k;
        k.level = c.level;
        k.fixed = fixed;
        k.prio  = c.prio;
        k.rank  = ~idx;
        return k;
    endfunction

    function automatic logic [VEC_W-1:0] to_vector(logic found, logic [IDX_W-1:0] src_num);
        return found ? (VEC_BASE + VEC_W'(src_num)) : VEC_SPURIOUS;
    endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output src_cfg_t [NUM_SRC-1:0] cfg,
    output logic                mask_all
);
    logic unused_wbit;
    assign unused_wbit = wdata[6];

    always_ff @(posedge clk) begin
        if (rst)
            mask_all <= 1'b0;
        else if (wr && addr == ADDR_GLOBAL)
            mask_all <= wdata[0];
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic mask_q;
        always_ff @(posedge clk) begin
            if (rst)
                mask_q <= 1'b1;
            else if (wr && addr == ADDR_W'(g + 1))
                mask_q <= wdata[7];
        end

        if (g < NUM_PROG) begin : g_prog
            logic [LVL_W-1:0] lvl_q;
            logic [PRI_W-1:0] pri_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    lvl_q <= '0;
                    pri_q <= '0;
                end else if (wr && addr == ADDR_W'(g + 1)) begin
                    lvl_q <= wdata[5:3];
                    pri_q <= wdata[2:0];
                end
            end
            assign cfg[g] = {mask_q, lvl_q, pri_q};

            assert_prog_write_R2: assert property (@(posedge clk) disable iff (rst)
                (wr && addr == ADDR_W'(g + 1)) |=> (cfg[g].level == $past(wdata[5:3])
                                                  && cfg[g].prio == $past(wdata[2:0])));
        end else begin : g_fixed
            assign cfg[g] = {mask_q, LVL_W'(g - NUM_PROG + 1), PRI_W'(0)};
        end
    end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
(
    input  logic [NUM_SRC-1:0]     req,
    input  src_cfg_t [NUM_SRC-1:0] cfg,
    input  logic                   mask_all,
    input  logic                   lvl_sel_en,
    input  logic [LVL_W-1:0]       lvl_sel,
    output logic                   found,
    output logic [IDX_W-1:0]       win_src,
    output logic [LVL_W-1:0]       win_level
);
    arb_key_t best;
    arb_key_t cand;

    always_comb begin
        best  = '0;
        cand  = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && !cfg[i].masked && cfg[i].level != '0 && !mask_all
                && (!lvl_sel_en || cfg[i].level == lvl_sel)) begin
                cand = make_key(cfg[i], i >= NUM_PROG, IDX_W'(i));
                if (!found || cand > best)
                    best = cand;
                found = 1'b1;
            end
        end
        win_src   = IDX_W'(~best.rank) + IDX_W'(1);
        win_level = found ? best.level : '0;
    end
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    output logic [LVL_W-1:0]   irq_level,
    output logic               wake,
    input  logic               ack_req,
    input  logic [LVL_W-1:0]   ack_lvl,
    output logic               ack_valid,
    output logic [VEC_W-1:0]   ack_vec
);
    src_cfg_t [NUM_SRC-1:0] cfg;
    logic                   mask_all;

    logic             top_found, ack_found;
    logic [IDX_W-1:0] top_src, ack_src;
    logic [LVL_W-1:0] top_level, unused_ack_level;
    src_cfg_t         rd_cfg;

    pic_regs i_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cfg(cfg), .mask_all(mask_all)
    );

    pic_arbiter i_arb_main (
        .req(irq_req), .cfg(cfg), .mask_all(mask_all),
        .lvl_sel_en(1'b0), .lvl_sel('0),
        .found(top_found), .win_src(top_src), .win_level(top_level)
    );

    pic_arbiter i_arb_ack (
        .req(irq_req), .cfg(cfg), .mask_all(mask_all),
        .lvl_sel_en(1'b1), .lvl_sel(ack_lvl),
        .found(ack_found), .win_src(ack_src), .win_level(unused_ack_level)
    );

    // Unclocked so it still works while the clock is gated in stop mode.
    assign wake = top_found;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_level <= '0;
            ack_valid <= 1'b0;
            ack_vec   <= VEC_SPURIOUS;
        end else begin
            irq_level <= top_level;
            ack_valid <= ack_req;
            if (ack_req)
                ack_vec <= to_vector(ack_found, ack_src);
        end
    end

    assign rd_cfg = cfg[IDX_W'(reg_addr - ADDR_W'(1))];

    always_comb begin
        if (reg_addr == ADDR_GLOBAL)
            reg_rdata = {{(DATA_W-1){1'b0}}, mask_all};
        else if (reg_addr == ADDR_ACK)
            reg_rdata = to_vector(top_found, top_src);
        else if (reg_addr <= ADDR_W'(NUM_SRC))
            reg_rdata = {rd_cfg.masked, 1'b0, rd_cfg.level, rd_cfg.prio};
        else
            reg_rdata = '0;
    end

    assert_maskall_level_R6: assert property (@(posedge clk) disable iff (rst)
        $past(mask_all) |-> irq_level == '0);
    assert_maskall_wake_R6: assert property (@(posedge clk) disable iff (rst)
        mask_all |-> !wake);
    assert_level_after_wake_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> $past(wake));
    assert_ack_timing_R10: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(ack_req));
    assert_ack_vec_range_R8: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> (ack_vec == VEC_SPURIOUS
                       || (ack_vec > VEC_BASE && ack_vec <= VEC_BASE + VEC_W'(NUM_SRC))));
    assert_ack_under_level_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_vec != VEC_SPURIOUS) |-> ($past(ack_lvl) != '0 && irq_level >= $past(ack_lvl)));
endmodule

// File: tb/test_pic_top.sv
module test_pic_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [6:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [62:0] irq_req;
    logic [2:0]  irq_level;
    logic        wake;
    logic        ack_req;
    logic [2:0]  ack_lvl;
    logic        ack_valid;
    logic [7:0]  ack_vec;

    int checks = 0;
    int failures = 0;

    bit     sh_mask [1:63];
    int     sh_lvl  [1:63];
    int     sh_pri  [1:63];
    bit     sh_mall;

    always #4 clk = ~clk;

    pic_top i_pic_top (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_level(irq_level), .wake(wake),
        .ack_req(ack_req), .ack_lvl(ack_lvl), .ack_valid(ack_valid), .ack_vec(ack_vec)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Bench model of the ranking rules; returns winning source number or 0.
    function automatic int model_win(bit sel, int lvl);
        int best = 0;
        for (int s = 1; s <= 63; s++) begin
            bit ok = irq_req[s-1] && !sh_mask[s] && sh_lvl[s] != 0 && !sh_mall
                     && (!sel || sh_lvl[s] == lvl);
            if (ok) begin
                if (best == 0) best = s;
                else if (sh_lvl[s] > sh_lvl[best]) best = s;
                else if (sh_lvl[s] == sh_lvl[best]) begin
                    if (s > 56 && best <= 56) best = s;
                    else if (s <= 56 && best <= 56 && sh_pri[s] > sh_pri[best]) best = s;
                end
            end
        end
        return best;
    endfunction

    function automatic int vec_of(int s);
        return (s == 0) ? 255 : 64 + s;
    endfunction

    task automatic write_reg(int a, int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 7'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cfg_src(int s, bit m, int l, int p);
        write_reg(s, {m, 1'b0, 3'(l), 3'(p)});
        sh_mask[s] = m;
        if (s <= 56) begin
            sh_lvl[s] = l;
            sh_pri[s] = p;
        end
    endtask

    task automatic read_reg(int a, output int v);
        @(negedge clk);
        reg_addr = 7'(a);
        #1 v = reg_rdata;
    endtask

    // Apply a request pattern and check wake, soft ack, level and a hardware ack.
    task automatic scenario(logic [62:0] pattern, int hw_lvl);
        int w;
        @(negedge clk);
        irq_req = pattern;
        reg_addr = 7'd64;
        #1;
        w = model_win(1'b0, 0);
        chk("R11 wake", wake, w != 0);
        chk("R9 soft ack vector", reg_rdata, vec_of(w));
        @(posedge clk); #1;
        chk("R4 irq_level", irq_level, (w == 0) ? 0 : sh_lvl[w]);
        @(negedge clk);
        ack_req = 1'b1; ack_lvl = 3'(hw_lvl);
        @(posedge clk); #1;
        chk("R10 ack_valid", ack_valid, 1);
        chk("R10 hw ack vector", ack_vec, vec_of(model_win(1'b1, hw_lvl)));
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v;
        void'($urandom(32'd20240611));
        for (int s = 1; s <= 63; s++) begin
            sh_mask[s] = 1'b1;
            sh_lvl[s]  = (s > 56) ? s - 56 : 0;
            sh_pri[s]  = 0;
        end
        sh_mall = 1'b0;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        irq_req = '0; ack_req = 1'b0; ack_lvl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        read_reg(1, v);  chk("R1 src1 reset", v, 8'h80);
        read_reg(56, v); chk("R1 src56 reset", v, 8'h80);
        read_reg(0, v);  chk("R1 global mask reset", v, 0);
        read_reg(57, v); chk("R3 src57 reset", v, 8'h88);
        read_reg(63, v); chk("R3 src63 reset", v, 8'hB8);
        @(negedge clk) irq_req = '1;
        #1 chk("R1 wake masked", wake, 0);
        @(posedge clk); #1 chk("R1 irq_level masked", irq_level, 0);
        @(negedge clk) irq_req = '0;

        // R2 write/readback, R3 fixed source ignores level/prio
        cfg_src(7, 1'b0, 5, 3);
        read_reg(7, v); chk("R2 readback", v, 8'h2B);
        write_reg(60, 8'h3F); sh_mask[60] = 1'b0;
        read_reg(60, v); chk("R3 fixed ignores write", v, 8'h20);

        // R5 level 0 disables
        cfg_src(5, 1'b0, 0, 7);
        scenario(63'(1) << 4, 0);
        // R7 ties: same level and priority -> lower number wins
        cfg_src(3, 1'b0, 4, 2);
        cfg_src(10, 1'b0, 4, 2);
        scenario((63'(1) << 2) | (63'(1) << 9), 4);
        @(negedge clk) reg_addr = 7'd64;
        #1 chk("R7 tie lower number", reg_rdata, 67);
        cfg_src(20, 1'b0, 4, 5);
        scenario((63'(1) << 2) | (63'(1) << 9) | (63'(1) << 19), 4);
        @(negedge clk) reg_addr = 7'd64;
        #1 chk("R7 higher priority", reg_rdata, 84);
        scenario((63'(1) << 2) | (63'(1) << 19) | (63'(1) << 59), 4);
        @(negedge clk) reg_addr = 7'd64;
        #1 chk("R7 fixed beats programmable", reg_rdata, 124);
        // R8 spurious on empty level, R10
        scenario((63'(1) << 59), 6);
        chk("R8 spurious ack", ack_vec, 255);

        // R6 global mask
        write_reg(0, 1); sh_mall = 1'b1;
        read_reg(0, v); chk("R6 global mask readback", v, 1);
        scenario((63'(1) << 59) | (63'(1) << 6), 4);
        chk("R6 irq_level zero", irq_level, 0);
        write_reg(0, 0); sh_mall = 1'b0;

        // Random configurations and requests
        for (int it = 0; it < 48; it++) begin
            if (it % 8 == 0) begin
                for (int s = 1; s <= 63; s++)
                    cfg_src(s, ($urandom % 3) == 0, $urandom % 8, $urandom % 8);
            end
            scenario({$urandom, $urandom} & {$urandom, $urandom}, $urandom % 8);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule